// File: doc/BRIEF.md
# Grouped-Cluster Route Computation Unit

This unit decides where a packet goes next in an on-chip network. Clients sit in clusters of eight, and each cluster hangs off four local routers. The clusters are laid out as a grid that is filled row by row, and the number of grid columns is supplied at run time. From the destination client number, the unit works out the destination cluster and the local router that serves that client. It then compares them with the cluster and router that hold the packet and picks one move: hand the packet to the attached client, pass it to a sibling router in the same cluster, or send it right, left, up or down across the grid.

The result is registered. It appears one clock after a valid request and stays in place until the next valid request arrives. A parameter table turns the chosen direction into a physical output port number. Two kinds of request are rejected with an error flag and a drop code: a destination cluster that lies beyond the configured number of clusters, and a column count outside 1..MAX_COLS.

Top module: `grid_route_unit`

## Requirements
- R1: While reset (active low) is asserted, and after it is released, out_valid_o, dir_o, port_o, dst_grp_o, dst_rtr_o and err_o are all zero until the first valid request.
- R2: A request accepted on a clock edge with in_valid_i high produces its result, with out_valid_o high, after that edge. When in_valid_i is low, out_valid_o goes low on the next edge and dir_o, port_o, dst_grp_o, dst_rtr_o and err_o keep their values.
- R3: dst_grp_o equals the destination client number divided by eight, rounded down.
- R4: dst_rtr_o depends on the offset of the client inside its cluster (client number mod 8): offsets 0 and 1 give router 0, offsets 2 and 3 give router 2, offsets 4 and 5 give router 1, and offsets 6 and 7 give router 3.
- R5: When the destination cluster equals cur_grp_i and the destination router equals cur_rtr_i, dir_o is 0 (deliver to the client).
- R6: When the clusters match and the routers differ, dir_o is 1 (go to the sibling router in the same cluster).
- R7: When the clusters differ but share a grid row, dir_o is 2 (right) if cur_grp_i is the smaller number and 3 (left) if it is the larger. The row of a cluster is its number divided by cols_i, rounded down.
- R8: When the grid rows differ, dir_o is 4 (up) if the current row is smaller than the destination row and 5 (down) if it is larger.
- R9: If the destination cluster is at or above NUM_GROUPS (default 20), or cols_i is 0 or greater than MAX_COLS (default 16), err_o is 1 and dir_o is 7 (drop). Otherwise err_o is 0 and dir_o is never above 5.
- R10: port_o is the entry of PORT_TABLE selected by dir_o. With the default table this gives 0 for code 0, 5 for code 2, 6 for code 3, 7 for code 4, 8 for code 5 and 15 for code 7. For code 1 the port is the table entry plus the destination router, which gives ports 1 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe; the inputs below are sampled when it is high |
| dst_id_i | input | CLIENT_W (8) | Destination client number |
| cur_grp_i | input | CLIENT_W-3 (5) | Cluster holding the packet |
| cur_rtr_i | input | 2 | Local router holding the packet |
| cols_i | input | COL_W (5) | Number of grid columns |
| out_valid_o | output | 1 | Result strobe, one cycle after the request |
| dir_o | output | 3 | Direction code |
| port_o | output | PORT_W (4) | Physical port for the direction |
| dst_grp_o | output | CLIENT_W-3 (5) | Computed destination cluster |
| dst_rtr_o | output | 2 | Computed destination router |
| err_o | output | 1 | Request rejected |

## Verification
The assertions assume that the clock edge sees no in_valid_i pulse while reset is held. They also assume that cur_grp_i names a cluster that exists, which is below NUM_GROUPS, because the unit never checks the current location. The stimulus meets both assumptions: in_valid_i stays low until reset is released, and every current cluster driven is below 20. Out-of-range values are applied only to the destination number and the column count, the two inputs that R9 is meant to reject.

// File: rtl/grid_route_pkg.sv
package grid_route_pkg;

   typedef enum logic [2:0] {
      DIR_LOCAL = 3'd0,
      DIR_INGRP = 3'd1,
      DIR_RIGHT = 3'd2,
      DIR_LEFT  = 3'd3,
      DIR_UP    = 3'd4,
      DIR_DOWN  = 3'd5,
      DIR_DROP  = 3'd7
   } route_dir_e;

   localparam int unsigned CLUSTER_LOG2 = 3;
   localparam int unsigned RTR_W        = 2;

   // Non-monotonic offset-to-router mapping: 0,1->0  2,3->2  4,5->1  6,7->3
   function automatic logic [RTR_W-1:0] offset_to_router(input logic [CLUSTER_LOG2-1:0] off);
      return {off[1], off[2]};
   endfunction

endpackage

// File: rtl/grid_route_div.sv
// Unrolled restoring divider: one compare/subtract stage per quotient bit.
module grid_route_div #(
   parameter int unsigned NUM_W = 5,
   parameter int unsigned DEN_W = 5
) (
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic [NUM_W-1:0] quo_o
);
   localparam int unsigned RW = DEN_W + 1;

   if (NUM_W < 1 || DEN_W < 1) begin : g_bad_width
      $error("grid_route_div: widths must be at least one bit");
   end

   logic [RW-1:0] rem [NUM_W];
   logic [RW-1:0] den_ext;

   assign den_ext = {1'b0, den_i};

   for (genvar i = 0; i < NUM_W; i++) begin : g_stage
      logic [RW-1:0] trial;
      if (i == 0) begin : g_first
         assign trial = {{(RW-1){1'b0}}, num_i[NUM_W-1]};
      end else begin : g_next
         assign trial = {rem[i-1][RW-2:0], num_i[NUM_W-1-i]};
      end
      assign quo_o[NUM_W-1-i] = (trial >= den_ext);
      assign rem[i] = quo_o[NUM_W-1-i] ? (trial - den_ext) : trial;
   end

endmodule

// File: rtl/grid_route_decode.sv
module grid_route_decode
   import grid_route_pkg::*;
#(
   parameter int unsigned CLIENT_W = 8,
   localparam int unsigned GRP_W   = CLIENT_W - CLUSTER_LOG2
) (
   input  logic [CLIENT_W-1:0] dst_id_i,
   output logic [GRP_W-1:0]    dst_grp_o,
   output logic [RTR_W-1:0]    dst_rtr_o
);
   if (CLIENT_W <= CLUSTER_LOG2) begin : g_bad_width
      $error("grid_route_decode: client number must be wider than the cluster offset");
   end

   assign dst_grp_o = dst_id_i[CLIENT_W-1:CLUSTER_LOG2];
   assign dst_rtr_o = offset_to_router(dst_id_i[CLUSTER_LOG2-1:0]);

endmodule

// File: rtl/grid_route_decide.sv
module grid_route_decide
   import grid_route_pkg::*;
#(
   parameter int unsigned GRP_W      = 5,
   parameter int unsigned COL_W      = 5,
   parameter int unsigned NUM_GROUPS = 20,
   parameter int unsigned MAX_COLS   = 16
) (
   input  logic [GRP_W-1:0] dst_grp_i,
   input  logic [RTR_W-1:0] dst_rtr_i,
   input  logic [GRP_W-1:0] cur_grp_i,
   input  logic [RTR_W-1:0] cur_rtr_i,
   input  logic [COL_W-1:0] cols_i,
   output route_dir_e       dir_o,
   output logic             err_o
);
   logic [GRP_W-1:0] cur_row, dst_row;
   logic             grp_range_bad, cols_bad;

   grid_route_div #(.NUM_W(GRP_W), .DEN_W(COL_W)) u_cur_row (
      .num_i(cur_grp_i), .den_i(cols_i), .quo_o(cur_row));

   grid_route_div #(.NUM_W(GRP_W), .DEN_W(COL_W)) u_dst_row (
      .num_i(dst_grp_i), .den_i(cols_i), .quo_o(dst_row));

   if (NUM_GROUPS >= (1 << GRP_W)) begin : g_full_range
      assign grp_range_bad = 1'b0;
   end else begin : g_part_range
      assign grp_range_bad = (dst_grp_i >= GRP_W'(NUM_GROUPS));
   end

   assign cols_bad = (cols_i == '0) || (cols_i > COL_W'(MAX_COLS));
   assign err_o    = grp_range_bad || cols_bad;

   always_comb begin
      if (err_o) begin
         dir_o = DIR_DROP;
      end else if (dst_grp_i == cur_grp_i) begin
         dir_o = (dst_rtr_i == cur_rtr_i) ? DIR_LOCAL : DIR_INGRP;
      end else if (dst_row == cur_row) begin
         dir_o = (cur_grp_i < dst_grp_i) ? DIR_RIGHT : DIR_LEFT;
      end else begin
         dir_o = (cur_row < dst_row) ? DIR_UP : DIR_DOWN;
      end
   end

endmodule

// File: rtl/grid_route_portmap.sv
module grid_route_portmap
   import grid_route_pkg::*;
#(
   parameter int unsigned     PORT_W       = 4,
   parameter logic [8*PORT_W-1:0] PORT_TABLE = '0,
   parameter bit              INGRP_OFFSET = 1'b1
) (
   input  route_dir_e       dir_i,
   input  logic [RTR_W-1:0] dst_rtr_i,
   output logic [PORT_W-1:0] port_o
);
   logic [PORT_W-1:0] base_port;

   always_comb begin
      base_port = PORT_TABLE[32'(dir_i)*PORT_W +: PORT_W];
   end

   if (INGRP_OFFSET) begin : g_ingrp_offset
      if (PORT_W < RTR_W) begin : g_bad_width
         $error("grid_route_portmap: port field too narrow for router offset");
      end
      assign port_o = (dir_i == DIR_INGRP) ? (base_port + PORT_W'(dst_rtr_i)) : base_port;
   end else begin : g_plain
      logic unused_rtr;
      assign unused_rtr = ^dst_rtr_i;
      assign port_o = base_port;
   end

endmodule

// File: rtl/grid_route_unit.sv
module grid_route_unit
   import grid_route_pkg::*;
#(
   parameter int unsigned CLIENT_W   = 8,
   parameter int unsigned NUM_GROUPS = 20,
   parameter int unsigned MAX_COLS   = 16,
   parameter int unsigned PORT_W     = 4,
   parameter logic [8*PORT_W-1:0] PORT_TABLE =
      {4'd15, 4'd15, 4'd8, 4'd7, 4'd6, 4'd5, 4'd1, 4'd0},
   parameter bit INGRP_OFFSET = 1'b1,
   localparam int unsigned GRP_W = CLIENT_W - CLUSTER_LOG2,
   localparam int unsigned COL_W = $clog2(MAX_COLS + 1)
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                in_valid_i,
   input  logic [CLIENT_W-1:0] dst_id_i,
   input  logic [GRP_W-1:0]    cur_grp_i,
   input  logic [RTR_W-1:0]    cur_rtr_i,
   input  logic [COL_W-1:0]    cols_i,
   output logic                out_valid_o,
   output logic [2:0]          dir_o,
   output logic [PORT_W-1:0]   port_o,
   output logic [GRP_W-1:0]    dst_grp_o,
   output logic [RTR_W-1:0]    dst_rtr_o,
   output logic                err_o
);
   if (NUM_GROUPS < 1 || NUM_GROUPS > (1 << GRP_W)) begin : g_bad_groups
      $error("grid_route_unit: NUM_GROUPS outside what CLIENT_W can address");
   end
   if (MAX_COLS < 1) begin : g_bad_cols
      $error("grid_route_unit: MAX_COLS must be at least one");
   end

   logic [GRP_W-1:0]  dst_grp_c;
   logic [RTR_W-1:0]  dst_rtr_c;
   route_dir_e        dir_c;
   logic              err_c;
   logic [PORT_W-1:0] port_c;

   grid_route_decode #(.CLIENT_W(CLIENT_W)) u_decode (
      .dst_id_i (dst_id_i),
      .dst_grp_o(dst_grp_c),
      .dst_rtr_o(dst_rtr_c));

   grid_route_decide #(
      .GRP_W(GRP_W), .COL_W(COL_W),
      .NUM_GROUPS(NUM_GROUPS), .MAX_COLS(MAX_COLS)
   ) u_decide (
      .dst_grp_i(dst_grp_c),
      .dst_rtr_i(dst_rtr_c),
      .cur_grp_i(cur_grp_i),
      .cur_rtr_i(cur_rtr_i),
      .cols_i   (cols_i),
      .dir_o    (dir_c),
      .err_o    (err_c));

   grid_route_portmap #(
      .PORT_W(PORT_W), .PORT_TABLE(PORT_TABLE), .INGRP_OFFSET(INGRP_OFFSET)
   ) u_portmap (
      .dir_i    (dir_c),
      .dst_rtr_i(dst_rtr_c),
      .port_o   (port_c));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         out_valid_o <= 1'b0;
         dir_o       <= '0;
         port_o      <= '0;
         dst_grp_o   <= '0;
         dst_rtr_o   <= '0;
         err_o       <= 1'b0;
      end else begin
         out_valid_o <= in_valid_i;
         if (in_valid_i) begin
            dir_o     <= 3'(dir_c);
            port_o    <= port_c;
            dst_grp_o <= dst_grp_c;
            dst_rtr_o <= dst_rtr_c;
            err_o     <= err_c;
         end
      end
   end

endmodule

// File: rtl/grid_route_chk.sv
module grid_route_chk #(
   parameter int unsigned CLIENT_W = 8,
   parameter int unsigned PORT_W   = 4,
   parameter logic [8*PORT_W-1:0] PORT_TABLE = '0,
   parameter int unsigned GRP_W    = 5,
   parameter int unsigned COL_W    = 5
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                in_valid_i,
   input logic [CLIENT_W-1:0] dst_id_i,
   input logic [1:0]          cur_rtr_i,
   input logic                out_valid_o,
   input logic [2:0]          dir_o,
   input logic [PORT_W-1:0]   port_o,
   input logic [GRP_W-1:0]    dst_grp_o,
   input logic [1:0]          dst_rtr_o,
   input logic                err_o
);
   // R2
   valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |=> out_valid_o);

   // R2
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid_i |=> (!out_valid_o && $stable(dir_o) && $stable(port_o)
                       && $stable(dst_grp_o) && $stable(err_o)));

   // R3
   dst_group_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |=> (dst_grp_o == $past(dst_id_i[CLIENT_W-1:3])));

   // R6
   sibling_differs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |=> ((dir_o != 3'd1) || (dst_rtr_o != $past(cur_rtr_i))));

   // R9
   drop_on_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && err_o) |-> (dir_o == 3'd7));

   // R9
   legal_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && !err_o) |-> (dir_o <= 3'd5));

   // R10
   local_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && dir_o == 3'd0) |-> (port_o == PORT_TABLE[PORT_W-1:0]));

   // R10
   drop_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && dir_o == 3'd7) |-> (port_o == PORT_TABLE[7*PORT_W +: PORT_W]));
endmodule

bind grid_route_unit grid_route_chk #(
   .CLIENT_W(CLIENT_W), .PORT_W(PORT_W), .PORT_TABLE(PORT_TABLE),
   .GRP_W(GRP_W), .COL_W(COL_W)
) chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
   .dst_id_i(dst_id_i), .cur_rtr_i(cur_rtr_i),
   .out_valid_o(out_valid_o), .dir_o(dir_o), .port_o(port_o),
   .dst_grp_o(dst_grp_o), .dst_rtr_o(dst_rtr_o), .err_o(err_o));

// File: tb/grid_route_unit_tb_top.sv
`timescale 1ns/1ps
module grid_route_unit_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] dst_id = '0;
   logic [4:0] cur_grp = '0;
   logic [1:0] cur_rtr = '0;
   logic [4:0] cols = 5'd4;
   logic       out_valid;
   logic [2:0] dir;
   logic [3:0] port;
   logic [4:0] dst_grp;
   logic [1:0] dst_rtr;
   logic       err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   grid_route_unit dut_i (
      .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid),
      .dst_id_i(dst_id), .cur_grp_i(cur_grp), .cur_rtr_i(cur_rtr), .cols_i(cols),
      .out_valid_o(out_valid), .dir_o(dir), .port_o(port),
      .dst_grp_o(dst_grp), .dst_rtr_o(dst_rtr), .err_o(err));

   // fields: dst(8) cur_grp(5) cur_rtr(2) cols(5) dir(3) port(4) err(1)
   localparam int NV = 21;
   localparam logic [27:0] VEC [NV] = '{
      {8'd0,   5'd0,  2'd0, 5'd4,  3'd0, 4'd0,  1'b0},   // R5
      {8'd13,  5'd1,  2'd1, 5'd4,  3'd0, 4'd0,  1'b0},   // R5
      {8'd13,  5'd1,  2'd3, 5'd4,  3'd1, 4'd2,  1'b0},   // R6
      {8'd22,  5'd2,  2'd0, 5'd4,  3'd1, 4'd4,  1'b0},   // R6
      {8'd26,  5'd1,  2'd0, 5'd4,  3'd2, 4'd5,  1'b0},   // R7
      {8'd8,   5'd3,  2'd2, 5'd4,  3'd3, 4'd6,  1'b0},   // R7
      {8'd100, 5'd2,  2'd0, 5'd4,  3'd4, 4'd7,  1'b0},   // R8
      {8'd40,  5'd14, 2'd0, 5'd4,  3'd5, 4'd8,  1'b0},   // R8
      {8'd40,  5'd3,  2'd0, 5'd1,  3'd4, 4'd7,  1'b0},   // R8 single column
      {8'd152, 5'd0,  2'd0, 5'd16, 3'd4, 4'd7,  1'b0},   // R8 widest grid
      {8'd72,  5'd15, 2'd0, 5'd16, 3'd3, 4'd6,  1'b0},   // R7 widest grid
      {8'd41,  5'd3,  2'd0, 5'd3,  3'd2, 4'd5,  1'b0},   // R7
      {8'd48,  5'd5,  2'd0, 5'd3,  3'd4, 4'd7,  1'b0},   // R8 row wrap
      {8'd159, 5'd13, 2'd0, 5'd7,  3'd4, 4'd7,  1'b0},   // R8
      {8'd104, 5'd19, 2'd0, 5'd7,  3'd5, 4'd8,  1'b0},   // R8
      {8'd159, 5'd19, 2'd3, 5'd7,  3'd0, 4'd0,  1'b0},   // R5 last cluster
      {8'd18,  5'd2,  2'd2, 5'd4,  3'd0, 4'd0,  1'b0},   // R5
      {8'd160, 5'd0,  2'd0, 5'd4,  3'd7, 4'd15, 1'b1},   // R9 first bad cluster
      {8'd255, 5'd5,  2'd0, 5'd4,  3'd7, 4'd15, 1'b1},   // R9
      {8'd0,   5'd0,  2'd0, 5'd0,  3'd7, 4'd15, 1'b1},   // R9 zero columns
      {8'd0,   5'd0,  2'd0, 5'd17, 3'd7, 4'd15, 1'b1}    // R9 too many columns
   };

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int ref_rtr(input int id);
      case (id % 8)
         0, 1: return 0;
         2, 3: return 2;
         4, 5: return 1;
         default: return 3;
      endcase
   endfunction

   function automatic int ref_dir(input int id, input int cg, input int cr, input int nc);
      int dg = id / 8;
      if (dg >= 20 || nc == 0 || nc > 16) return 7;
      if (dg == cg) return (ref_rtr(id) == cr) ? 0 : 1;
      if (dg / nc == cg / nc) return (cg < dg) ? 2 : 3;
      return (cg / nc < dg / nc) ? 4 : 5;
   endfunction

   function automatic int ref_port(input int d, input int rtr);
      case (d)
         0: return 0;
         1: return 1 + rtr;
         2: return 5;
         3: return 6;
         4: return 7;
         5: return 8;
         default: return 15;
      endcase
   endfunction

   task automatic apply(input int id, input int cg, input int cr, input int nc);
      @(negedge clk);
      dst_id = 8'(id); cur_grp = 5'(cg); cur_rtr = 2'(cr); cols = 5'(nc);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R2 watchdog: actual 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      // R1 during reset
      check("R1", "valid in reset", int'(out_valid), 0);
      check("R1", "dir in reset", int'(dir), 0);
      check("R1", "port in reset", int'(port), 0);
      check("R1", "grp/rtr/err in reset", int'({dst_grp, dst_rtr, err}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", "valid after release", int'(out_valid), 0);
      check("R1", "dir after release", int'(dir), 0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [27:0] v = VEC[i];
         apply(int'(v[27:20]), int'(v[19:15]), int'(v[14:13]), int'(v[12:8]));
         check("R2", $sformatf("vec %0d valid", i), int'(out_valid), 1);
         check("R5-R8 dir", $sformatf("vec %0d dir", i), int'(dir), int'(v[7:5]));
         check("R10", $sformatf("vec %0d port", i), int'(port), int'(v[4:1]));
         check("R9", $sformatf("vec %0d err", i), int'(err), int'(v[0]));
      end

      // R2 hold: inputs change without a strobe
      apply(100, 2, 0, 4);
      dst_id = 8'd0; cur_grp = 5'd0; cur_rtr = 2'd0; cols = 5'd0;
      repeat (3) @(negedge clk);
      check("R2", "valid drops when idle", int'(out_valid), 0);
      check("R2", "dir held when idle", int'(dir), 4);
      check("R2", "port held when idle", int'(port), 7);
      check("R2", "grp held when idle", int'(dst_grp), 12);

      // R3 / R4 sweep across every legal destination
      for (int id = 0; id < 160; id++) begin
         apply(id, 7, 1, 5);
         check("R3", $sformatf("grp of %0d", id), int'(dst_grp), id / 8);
         check("R4", $sformatf("rtr of %0d", id), int'(dst_rtr), ref_rtr(id));
         check("R7", $sformatf("dir of %0d", id), int'(dir), ref_dir(id, 7, 1, 5));
         check("R10", $sformatf("port of %0d", id), int'(port),
               ref_port(ref_dir(id, 7, 1, 5), ref_rtr(id)));
      end

      // R8 sweep of column counts, including the illegal ends
      for (int nc = 0; nc < 20; nc++) begin
         apply(150, 3, 0, nc);
         check("R8", $sformatf("dir cols %0d", nc), int'(dir), ref_dir(150, 3, 0, nc));
         check("R9", $sformatf("err cols %0d", nc), int'(err), (nc == 0 || nc > 16) ? 1 : 0);
      end

      // R1 reset in mid-run clears results
      apply(100, 2, 0, 4);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", "dir after mid reset", int'(dir), 0);
      check("R1", "grp after mid reset", int'(dst_grp), 0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule